// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a 32-bit down-counting watchdog that software keeps alive by reloading it before it runs out. While enabled, the counter loses one count per clock cycle. When it reaches zero it reloads from the load register and sets an interrupt status bit. The interrupt output is that bit gated by the enable. If the counter runs out a second time while the status bit is still set, and reset escalation is enabled, the block raises a one-cycle reset request. The status is cleared by writing the clear register, and that write also restarts the countdown.

The configuration is protected against runaway code by a lock. Writing the 32-bit key 0x1ACCE551 to the lock register unlocks the block, and writing any other value locks it. While the block is locked, writes to the load, control and clear registers are dropped. The lock register itself is always writable. The block sits on a simple single-cycle register bus. Reads are combinational from the selected register. Writes take effect at the clock edge on which select and write are both high. There is no data stream and no handshake: every access completes in one cycle.

Top module: `wdg_lock_top`

## Requirements
- R1: After reset, the load register (word offset 0) and the current value (offset 1) read 0xFFFFFFFF, the control register (offset 2), raw status (offset 4), masked status (offset 5) and lock register (offset 6) read 0, and both irq_o and rst_req_o are low.
- R2: An accepted write to the load register stores the data, and in the next cycle the current value equals the written data.
- R3: While control bit 0 (run) is 1, the current value drops by exactly one per cycle. While run is 0, it holds its value.
- R4: When the current value is 0 and run is 1, the next cycle shows the current value equal to the load register and raw status bit 0 set to 1.
- R5: Masked status bit 0 and irq_o both equal raw status AND run. With run at 0 they are low even while raw status is 1.
- R6: A time-out that occurs while raw status is already 1 and control bit 1 (reset enable) is 1 drives rst_req_o high for exactly one cycle. With reset enable at 0, the same event leaves rst_req_o low.
- R7: An accepted write of any value to the clear register (offset 3) makes raw status read 0 and the current value equal the load register in the next cycle.
- R8: Writing 0x1ACCE551 to offset 6 unlocks the block and writing any other value locks it. Offset 6 reads 1 while locked and 0 while unlocked.
- R9: While the block is locked, writes to offsets 0, 2 and 3 change no register, status or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read select, 0 otherwise |
| irq_o | output | 1 | Masked time-out interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong count or a wrong reload shows in the current-value register on the very next read. Time-out misplacement shifts the raw status edge by the same number of cycles, so the bench samples status on the exact cycle the count reaches zero plus one. A status bit that clears or escalates wrongly appears as a missing or extra one-cycle reset pulse one full period later. The bench checks the cycle of that pulse and the cycle that follows it. A broken lock shows at once as a load or control register that reads back a value written while locked.

// File: rtl/wdg_lock_pkg.sv
package wdg_lock_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef enum logic [ADDR_W-1:0] {
    RG_LOAD  = 3'd0,
    RG_VALUE = 3'd1,
    RG_CTRL  = 3'd2,
    RG_CLEAR = 3'd3,
    RG_RAW   = 3'd4,
    RG_MASK  = 3'd5,
    RG_LOCK  = 3'd6
  } wdg_reg_e;

  typedef struct packed {
    logic rst_en;
    logic run;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
  import wdg_lock_pkg::*;
#(
  parameter int unsigned DW = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] cnt_val,
  input  logic          status,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] load_q,
  output wdg_ctrl_t     ctrl_q,
  output logic          load_wr,
  output logic          clear_wr,
  output logic          locked
);
  logic wr_any;
  logic cfg_ok;
  logic ctrl_wr;
  logic lock_wr;

  assign wr_any   = bus_sel & bus_wr;
  assign cfg_ok   = wr_any & ~locked;
  assign load_wr  = cfg_ok & (bus_addr == RG_LOAD);
  assign ctrl_wr  = cfg_ok & (bus_addr == RG_CTRL);
  assign clear_wr = cfg_ok & (bus_addr == RG_CLEAR);
  assign lock_wr  = wr_any & (bus_addr == RG_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '1;
      ctrl_q <= '0;
      locked <= 1'b0;
    end else begin
      if (load_wr) load_q <= bus_wdata;
      if (ctrl_wr) begin
        ctrl_q.run    <= bus_wdata[0];
        ctrl_q.rst_en <= bus_wdata[1];
      end
      if (lock_wr) locked <= (bus_wdata != UNLOCK_KEY);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        RG_LOAD:  bus_rdata = load_q;
        RG_VALUE: bus_rdata = cnt_val;
        RG_CTRL:  bus_rdata = DW'({ctrl_q.rst_en, ctrl_q.run});
        RG_RAW:   bus_rdata = DW'(status);
        RG_MASK:  bus_rdata = DW'(status & ctrl_q.run);
        RG_LOCK:  bus_rdata = DW'(locked);
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_LOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_any && bus_addr == RG_LOAD) |=> $stable(load_q)); // R9
  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_any && bus_addr == RG_CTRL) |=> $stable(ctrl_q)); // R9
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == RG_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked); // R8
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_lock_pkg::*;
#(
  parameter int unsigned DW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load_wr,
  input  logic [DW-1:0] load_data,
  input  logic          clear_wr,
  input  logic [DW-1:0] load_q,
  output logic [DW-1:0] cnt_val,
  output logic          timeout
);
  localparam logic [DW-1:0] ONE = DW'(1);

  assign timeout = run & (cnt_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val <= '1;
    end else if (load_wr) begin
      cnt_val <= load_data;
    end else if (clear_wr || timeout) begin
      cnt_val <= load_q;
    end else if (run) begin
      cnt_val <= cnt_val - ONE;
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_wr && !clear_wr && cnt_val != '0) |=> cnt_val == $past(cnt_val) - ONE); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_wr && !clear_wr) |=> $stable(cnt_val)); // R3
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !load_wr) |=> cnt_val == $past(load_q)); // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt_val == $past(load_data)); // R2
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic clear_wr,
  input  logic rst_en,
  output logic status,
  output logic rst_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= timeout & status & rst_en & ~clear_wr;
      if (clear_wr)     status <= 1'b0;
      else if (timeout) status <= 1'b1;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse); // R6
  AST_RST_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !status) |=> !rst_pulse); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |=> !status); // R7
  AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !clear_wr) |=> status); // R4
endmodule

// File: rtl/wdg_lock_top.sv
module wdg_lock_top
  import wdg_lock_pkg::*;
#(
  parameter int unsigned DW = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic [DW-1:0] load_q;
  logic [DW-1:0] cnt_val;
  wdg_ctrl_t     ctrl_q;
  logic          load_wr;
  logic          clear_wr;
  logic          locked;
  logic          timeout;
  logic          status;

  wdg_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .status    (status),
    .bus_rdata (bus_rdata),
    .load_q    (load_q),
    .ctrl_q    (ctrl_q),
    .load_wr   (load_wr),
    .clear_wr  (clear_wr),
    .locked    (locked)
  );

  wdg_counter #(.DW(DW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .load_wr   (load_wr),
    .load_data (bus_wdata),
    .clear_wr  (clear_wr),
    .load_q    (load_q),
    .cnt_val   (cnt_val),
    .timeout   (timeout)
  );

  wdg_escalate u_esc (
    .clk       (clk),
    .rst_n     (rst_n),
    .timeout   (timeout),
    .clear_wr  (clear_wr),
    .rst_en    (ctrl_q.rst_en),
    .status    (status),
    .rst_pulse (rst_req_o)
  );

  assign irq_o = status & ctrl_q.run;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !irq_o); // R5
  AST_LOCKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_sel && bus_wr && bus_addr == RG_CLEAR && !timeout) |=> $stable(status)); // R9
endmodule

// File: tb/wdg_lock_top_tb.sv
`timescale 1ns/100ps
module wdg_lock_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdg_lock_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  localparam logic [31:0] KEY = 32'h1ACC_E551;
  // {write, offset, data, expected read}
  localparam int NV = 17;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 3'd6, 32'h0, 32'h0},            // R1 lock reads 0
    {1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF},    // R1 load
    {1'b0, 3'd1, 32'h0, 32'hFFFF_FFFF},    // R1 value
    {1'b0, 3'd2, 32'h0, 32'h0},            // R1 ctrl
    {1'b0, 3'd4, 32'h0, 32'h0},            // R1 raw
    {1'b1, 3'd0, 32'h40, 32'h0},           // R2 write load
    {1'b0, 3'd1, 32'h0, 32'h40},           // R2 value follows
    {1'b1, 3'd6, 32'h1234_5678, 32'h0},    // R8 lock
    {1'b0, 3'd6, 32'h0, 32'h1},            // R8 reads 1
    {1'b1, 3'd0, 32'h99, 32'h0},           // R9 ignored
    {1'b0, 3'd0, 32'h0, 32'h40},           // R9 load kept
    {1'b0, 3'd1, 32'h0, 32'h40},           // R9 value kept
    {1'b1, 3'd2, 32'h3, 32'h0},            // R9 ignored
    {1'b0, 3'd2, 32'h0, 32'h0},            // R9 ctrl kept
    {1'b1, 3'd6, KEY, 32'h0},              // R8 unlock
    {1'b0, 3'd6, 32'h0, 32'h0},            // R8 reads 0
    {1'b0, 3'd1, 32'h0, 32'h40}            // R3 stopped, still 0x40
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v0;
    logic [31:0] v1;
    tick(3);
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    check("R1 rst_req_o", {31'b0, rst_req_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
      else begin
        tick(1);
        rd_chk($sformatf("vector %0d", i), VEC[i][66:64], VEC[i][31:0]);
      end
    end

    // R4 first time-out, R3 decrement
    wr(3'd0, 32'd5);
    wr(3'd2, 32'd1);                 // e0: run, count 5
    tick(2);  rd_chk("R3 count after 2", 3'd1, 32'd3);
    tick(3);  rd_chk("R3 count at zero", 3'd1, 32'd0);
    rd_chk("R4 raw before time-out", 3'd4, 32'd0);
    tick(1);  rd_chk("R4 raw set", 3'd4, 32'd1);
    rd_chk("R4 reloaded", 3'd1, 32'd5);
    check("R5 irq_o with run", {31'b0, irq_o}, 32'h1);
    // R6 second time-out without reset enable
    tick(6);
    check("R6 no pulse when disabled", {31'b0, rst_req_o}, 32'h0);
    rd_chk("R4 second reload", 3'd1, 32'd5);

    // R7 clear
    wr(3'd3, 32'hDEAD);
    rd_chk("R7 raw cleared", 3'd4, 32'd0);
    rd_chk("R7 count reloaded", 3'd1, 32'd5);
    check("R7 irq_o low", {31'b0, irq_o}, 32'h0);

    // R6 escalation
    wr(3'd2, 32'd3);
    wr(3'd0, 32'd3);                 // f0: count 3
    tick(4);
    rd_chk("R4 raw after f4", 3'd4, 32'd1);
    check("R6 no pulse on first", {31'b0, rst_req_o}, 32'h0);
    tick(3);
    check("R6 no pulse before second", {31'b0, rst_req_o}, 32'h0);
    tick(1);
    check("R6 pulse on second", {31'b0, rst_req_o}, 32'h1);
    tick(1);
    check("R6 pulse one cycle", {31'b0, rst_req_o}, 32'h0);

    // R5 mask, R3 hold
    wr(3'd2, 32'd0);
    rd_chk("R5 raw kept", 3'd4, 32'd1);
    rd_chk("R5 masked low", 3'd5, 32'd0);
    check("R5 irq_o masked", {31'b0, irq_o}, 32'h0);
    rd(3'd1, v0);
    tick(3);
    rd(3'd1, v1);
    check("R3 hold when stopped", v1, v0);

    // R9 locked clear and control
    wr(3'd6, 32'h0);
    wr(3'd3, 32'h1);
    rd_chk("R9 locked clear ignored", 3'd4, 32'd1);
    wr(3'd2, 32'd1);
    rd_chk("R9 locked ctrl ignored", 3'd2, 32'd0);
    rd_chk("R8 locked reads 1", 3'd6, 32'd1);
    wr(3'd6, KEY);
    rd_chk("R8 key unlocks", 3'd6, 32'd0);

    // R1 reset mid-operation
    wr(3'd2, 32'd1);
    wr(3'd6, 32'h5);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    rd_chk("R1 value after reset", 3'd1, 32'hFFFF_FFFF);
    rd_chk("R1 lock after reset", 3'd6, 32'd0);
    rd_chk("R1 raw after reset", 3'd4, 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule